// File: doc/BRIEF.md
# Continuous Capture Frequency Counter

This block measures the frequency of a digital signal by counting its rising edges without ever stopping. A slow gate waveform is made in a separate timebase clock domain from a tick enable. Each rising edge of that gate, once synchronized into the count clock domain, takes a snapshot of the running count. The snapshot is pushed into a small result queue, and an interrupt flag is raised. With the default settings a 1 kHz tick produces a 1 Hz gate, so each captured value is the input frequency in hertz.

A mode input chooses between two ways of handling the count at a capture. In interval mode the count restarts at every capture, and no edges are lost at the boundary. In run mode the count keeps growing, and software subtracts consecutive results. Software reads results one at a time through a pop strobe. It reads a status word, and that read clears the interrupt and the sticky error bits.

Top module: `freq_counter`

## Requirements
- R1: The edge count is `COUNT_W` bits wide (default 24). It counts every rising edge of `sig_in` with no start or stop control, and it is cleared only by reset or, in interval mode, by a capture.
- R2: The gate generator advances one step on each timebase cycle with `tick_en` high, and it repeats every `PERIOD_MAX`+1 steps (default 999, giving 1000 steps). While `tick_en` is low it holds, so `gate_o` stays constant and no captures occur.
- R3: `gate_o` is high for the first `CMP` steps of each period and low for the rest. With the default 500 of 1000 this gives a 50% duty cycle.
- R4: The gate passes through a two-stage synchronizer into the `clk` domain. Exactly one capture fires for each rising edge of `gate_o`, so captures are spaced one gate period apart.
- R5: A capture pushes the count into a FIFO of `FIFO_DEPTH` entries (default 4). `rd_data` shows the oldest entry, a one-cycle `rd_en` pops it, and `fifo_level` gives the number held. `status` bits are: [0] interrupt pending, [1] FIFO empty, [2] FIFO full, [3] overrun, [4] count wrap. After reset `status` is 5'b00010.
- R6: With `clr_on_cap`=1 the count restarts at a capture. An input edge seen in the capture cycle counts as 1 in the new interval, so each result equals the edges between two captures.
- R7: With `clr_on_cap`=0 the count is never cleared by a capture. Consecutive results differ, modulo 2^`COUNT_W`, by the edges in one gate period.
- R8: `irq` is set in the cycle after every capture, including a capture whose value is dropped.
- R9: A one-cycle `stat_rd` clears the interrupt, overrun and wrap bits, and `status` shows their values before the clear. A capture in the same cycle keeps the interrupt set.
- R10: `rd_en` while the FIFO is empty sees `rd_data`=0 and changes neither the level nor `status`.
- R11: A capture when the FIFO is full, with no pop in the same cycle, drops the new value, keeps the stored entries and sets the sticky overrun bit.
- R12: A count that wraps from all ones to zero on an input edge sets the sticky wrap bit. Interval mode at rates below 2^`COUNT_W` edges per period never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst | input | 1 | Synchronous active-high reset, held across several timebase cycles |
| sig_in | input | 1 | Signal under measurement, asynchronous |
| clr_on_cap | input | 1 | 1: restart count at each capture; 0: free running |
| tb_clk | input | 1 | Timebase clock for the gate generator |
| tick_en | input | 1 | Timebase step enable, `tb_clk` domain |
| gate_o | output | 1 | Generated gate waveform, `tb_clk` domain |
| rd_en | input | 1 | Pop the oldest result |
| rd_data | output | COUNT_W | Oldest result, zero when empty |
| fifo_level | output | $clog2(FIFO_DEPTH+1) | Number of stored results |
| stat_rd | input | 1 | Status read strobe, clears pending and sticky bits |
| status | output | 5 | {wrap, overrun, full, empty, pending} |
| irq | output | 1 | Capture interrupt |

## Verification
The bench builds the block with `COUNT_W`=8, `PERIOD_MAX`=9 and `CMP`=5, and runs the timebase clock at one eighth of the count clock. A gate period is then 80 count cycles, and the 40/40 duty split, the capture spacing, the fill of the FIFO and the overrun after it all occur within a few hundred cycles. The 8-bit count wraps after 256 edges, so run mode reaches the wrap bit. Interval mode at 40 edges per period shows that the wrap bit stays clear.

// File: rtl/fcnt_pkg.sv
`timescale 1ns/1ps
package fcnt_pkg;

    localparam int STAT_W = 5;

    // Status word, MSB first: wrap, overrun, full, empty, pending
    typedef struct packed {
        logic wrap;
        logic overrun;
        logic full;
        logic empty;
        logic pending;
    } fc_status_t;

    typedef enum logic {
        CNT_FREE_RUN = 1'b0,
        CNT_INTERVAL = 1'b1
    } fc_mode_e;

    function automatic logic is_rise(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/fc_sync.sv
`timescale 1ns/1ps
module fc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) chain <= d;
        end else begin : g_many
            always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d};
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fc_gate_gen.sv
`timescale 1ns/1ps
module fc_gate_gen #(
    parameter int PERIOD_MAX = 999,
    parameter int CMP        = 500
) (
    input  logic tb_clk,
    input  logic tb_rst,
    input  logic tick_en,
    output logic gate
);
    localparam int CW = $clog2(PERIOD_MAX + 1) + 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD_MAX);
    localparam logic [CW-1:0] THR  = CW'(CMP);

    logic [CW-1:0] step_q;
    logic [CW-1:0] step_nxt;

    always_comb begin
        step_nxt = (step_q == LAST) ? '0 : step_q + CW'(1);
    end

    // Reset parks on the last step so the first tick opens a period high.
    always_ff @(posedge tb_clk) begin
        if (tb_rst) begin
            step_q <= LAST;
            gate   <= 1'b0;
        end else if (tick_en) begin
            step_q <= step_nxt;
            gate   <= (step_nxt < THR);
        end
    end
endmodule

// File: rtl/fc_gate_capture.sv
`timescale 1ns/1ps
module fc_gate_capture
    import fcnt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_async,
    output logic cap
);
    logic gate_s;
    logic gate_prev;

    fc_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk (clk),
        .d   (gate_async),
        .q   (gate_s)
    );

    always_ff @(posedge clk) begin
        if (rst) gate_prev <= 1'b0;
        else     gate_prev <= gate_s;
    end

    assign cap = is_rise(gate_s, gate_prev);
endmodule

// File: rtl/fc_edge_counter.sv
`timescale 1ns/1ps
module fc_edge_counter
    import fcnt_pkg::*;
#(
    parameter int COUNT_W     = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sig_async,
    input  logic               cap,
    input  fc_mode_e           mode,
    output logic [COUNT_W-1:0] count_q,
    output logic               wrap
);
    logic sig_s;
    logic sig_prev;
    logic hit;
    logic restart;

    fc_sync #(.STAGES(SYNC_STAGES)) u_sig_sync (
        .clk (clk),
        .d   (sig_async),
        .q   (sig_s)
    );

    always_ff @(posedge clk) begin
        if (rst) sig_prev <= 1'b0;
        else     sig_prev <= sig_s;
    end

    assign hit     = is_rise(sig_s, sig_prev);
    assign restart = cap && (mode == CNT_INTERVAL);
    assign wrap    = hit && (&count_q) && !restart;

    always_ff @(posedge clk) begin
        if (rst)          count_q <= '0;
        else if (restart) count_q <= COUNT_W'(hit);
        else if (hit)     count_q <= count_q + COUNT_W'(1);
    end
endmodule

// File: rtl/fc_result_fifo.sv
`timescale 1ns/1ps
module fc_result_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          full,
    output logic          drop
);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    logic [W-1:0]  slot [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          push_ok, pop_ok;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PW'(1);
    endfunction

    assign empty   = (level == '0);
    assign full    = (level == FULL_LVL);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign drop    = push && !push_ok;
    assign head    = empty ? '0 : slot[rp];

    always_ff @(posedge clk) begin
        if (push_ok) slot[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push_ok) wp <= bump(wp);
            if (pop_ok)  rp <= bump(rp);
            case ({push_ok, pop_ok})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/freq_counter.sv
`timescale 1ns/1ps
module freq_counter
    import fcnt_pkg::*;
#(
    parameter int COUNT_W     = 24,
    parameter int FIFO_DEPTH  = 4,
    parameter int PERIOD_MAX  = 999,
    parameter int CMP         = 500,
    parameter int SYNC_STAGES = 2,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sig_in,
    input  logic               clr_on_cap,
    input  logic               tb_clk,
    input  logic               tick_en,
    output logic               gate_o,
    input  logic               rd_en,
    output logic [COUNT_W-1:0] rd_data,
    output logic [LVL_W-1:0]   fifo_level,
    input  logic               stat_rd,
    output logic [STAT_W-1:0]  status,
    output logic               irq
);
    logic               tb_rst;
    logic               cap_pulse;
    logic               cap_drop;
    logic               cnt_wrap;
    logic [COUNT_W-1:0] count_q;
    logic               q_empty, q_full;
    logic               pend_q, ovr_q, wrap_q;
    fc_mode_e           mode;
    fc_status_t         stat_s;

    assign mode = clr_on_cap ? CNT_INTERVAL : CNT_FREE_RUN;

    // Timebase domain: local copy of the reset, then the gate generator
    fc_sync #(.STAGES(SYNC_STAGES)) u_tb_rst_sync (
        .clk (tb_clk),
        .d   (rst),
        .q   (tb_rst)
    );

    fc_gate_gen #(.PERIOD_MAX(PERIOD_MAX), .CMP(CMP)) u_gate_gen (
        .tb_clk  (tb_clk),
        .tb_rst  (tb_rst),
        .tick_en (tick_en),
        .gate    (gate_o)
    );

    // Count domain
    fc_gate_capture #(.SYNC_STAGES(SYNC_STAGES)) u_gate_cap (
        .clk        (clk),
        .rst        (rst),
        .gate_async (gate_o),
        .cap        (cap_pulse)
    );

    fc_edge_counter #(.COUNT_W(COUNT_W), .SYNC_STAGES(SYNC_STAGES)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .sig_async (sig_in),
        .cap       (cap_pulse),
        .mode      (mode),
        .count_q   (count_q),
        .wrap      (cnt_wrap)
    );

    fc_result_fifo #(.W(COUNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (cap_pulse),
        .din   (count_q),
        .pop   (rd_en),
        .head  (rd_data),
        .level (fifo_level),
        .empty (q_empty),
        .full  (q_full),
        .drop  (cap_drop)
    );

    // Pending and sticky bits: a new event wins over a clearing read
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            ovr_q  <= 1'b0;
            wrap_q <= 1'b0;
        end else begin
            if (cap_pulse)    pend_q <= 1'b1;
            else if (stat_rd) pend_q <= 1'b0;
            if (cap_drop)     ovr_q  <= 1'b1;
            else if (stat_rd) ovr_q  <= 1'b0;
            if (cnt_wrap)     wrap_q <= 1'b1;
            else if (stat_rd) wrap_q <= 1'b0;
        end
    end

    always_comb begin
        stat_s.wrap    = wrap_q;
        stat_s.overrun = ovr_q;
        stat_s.full    = q_full;
        stat_s.empty   = q_empty;
        stat_s.pending = pend_q;
    end

    assign status = stat_s;
    assign irq    = pend_q;
endmodule

// File: rtl/freq_counter_checker.sv
`timescale 1ns/1ps
module freq_counter_checker #(
    parameter int FIFO_DEPTH = 4,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             cap,
    input logic             drop,
    input logic             rd_en,
    input logic             stat_rd,
    input logic             irq,
    input logic [LVL_W-1:0] level,
    input logic [4:0]       status
);
    // R4: one capture per gate edge, never two cycles in a row
    assert_single_capture_R4: assert property (@(posedge clk) disable iff (rst)
        cap |=> !cap);

    // R8: every capture leaves the interrupt pending
    assert_irq_after_capture_R8: assert property (@(posedge clk) disable iff (rst)
        cap |=> irq);

    // R9: status read with no capture clears the pending interrupt
    assert_status_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !cap) |=> !irq);

    // R9: capture coinciding with a status read keeps the interrupt
    assert_capture_beats_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && cap) |=> irq);

    // R10: pop on empty with no capture leaves the queue empty
    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && level == '0 && !cap) |=> (level == '0));

    // R11: a dropped capture sets overrun and keeps the queue full
    assert_overrun_on_drop_R11: assert property (@(posedge clk) disable iff (rst)
        drop |=> (status[3] && level == LVL_W'(FIFO_DEPTH)));

    // R5: empty and full flags are exclusive and the level is bounded
    assert_fifo_flags_R5: assert property (@(posedge clk) disable iff (rst)
        !(status[1] && status[2]) && (level <= LVL_W'(FIFO_DEPTH)));
endmodule

bind freq_counter freq_counter_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_checker (
    .clk     (clk),
    .rst     (rst),
    .cap     (cap_pulse),
    .drop    (cap_drop),
    .rd_en   (rd_en),
    .stat_rd (stat_rd),
    .irq     (irq),
    .level   (fifo_level),
    .status  (status)
);

// File: tb/freq_counter_bench.sv
`timescale 1ns/1ps
module freq_counter_bench;
    localparam int CW    = 8;
    localparam int DEPTH = 4;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk, tb_clk, rst;
    logic          sig_in, clr_on_cap, tick_en, rd_en, stat_rd;
    logic          gate_o, irq;
    logic [CW-1:0] rd_data;
    logic [LW-1:0] fifo_level;
    logic [4:0]    status;

    int checks = 0;
    int errors = 0;
    int sig_half = 0;
    bit done = 0;

    freq_counter #(
        .COUNT_W(CW), .FIFO_DEPTH(DEPTH), .PERIOD_MAX(9), .CMP(5), .SYNC_STAGES(2)
    ) u_freq_counter (
        .clk(clk), .rst(rst), .sig_in(sig_in), .clr_on_cap(clr_on_cap),
        .tb_clk(tb_clk), .tick_en(tick_en), .gate_o(gate_o),
        .rd_en(rd_en), .rd_data(rd_data), .fifo_level(fifo_level),
        .stat_rd(stat_rd), .status(status), .irq(irq)
    );

    initial begin clk = 0; forever #2.5 clk = ~clk; end
    initial begin tb_clk = 0; #1; forever #20 tb_clk = ~tb_clk; end

    // Measured signal: toggles every sig_half count cycles (0 = idle low)
    initial begin
        int ph = 0;
        sig_in = 0;
        forever begin
            @(negedge clk);
            if (sig_half == 0) begin sig_in = 0; ph = 0; end
            else if (ph >= sig_half - 1) begin sig_in = ~sig_in; ph = 0; end
            else ph++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input bit tick, input bit clr);
        rst = 1; rd_en = 0; stat_rd = 0; tick_en = tick; clr_on_cap = clr;
        repeat (40) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic pulse_stat();
        stat_rd = 1; @(negedge clk); stat_rd = 0;
    endtask

    task automatic pop(output int v);
        v = int'(rd_data);
        rd_en = 1; @(negedge clk); rd_en = 0;
    endtask

    task automatic wait_level(input int n, output bit ok);
        ok = 0;
        for (int i = 0; i < 2000; i++) begin
            if (int'(fifo_level) >= n) begin ok = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic wait_irq(output bit ok, output int cyc);
        ok = 0; cyc = 0;
        for (int i = 0; i < 2000; i++) begin
            if (irq) begin ok = 1; break; end
            @(negedge clk); cyc++;
        end
    endtask

    task automatic test_reset_state();
        do_reset(1'b0, 1'b1);
        check(status == 5'b00010, "R5", "status after reset", status, 2);
        check(fifo_level == 0, "R5", "level after reset", fifo_level, 0);
        check(irq == 0, "R8", "irq after reset", irq, 0);
    endtask

    task automatic test_empty_read();
        int v;
        check(rd_data == 0, "R10", "rd_data while empty", rd_data, 0);
        pop(v);
        @(negedge clk);
        check(v == 0, "R10", "popped value while empty", v, 0);
        check(fifo_level == 0, "R10", "level after empty pop", fifo_level, 0);
        check(status == 5'b00010, "R10", "status after empty pop", status, 2);
    endtask

    task automatic test_gate_shape();
        int hi = 0, lo = 0, n = 0;
        do_reset(1'b1, 1'b1);
        while (gate_o && n < 500) begin @(negedge clk); n++; end
        while (!gate_o && n < 500) begin @(negedge clk); n++; end
        while (gate_o && n < 500) begin @(negedge clk); hi++; n++; end
        while (!gate_o && n < 500) begin @(negedge clk); lo++; n++; end
        check(hi == 40, "R3", "gate high cycles", hi, 40);
        check(lo == 40, "R3", "gate low cycles", lo, 40);
        check(hi + lo == 80, "R2", "gate period cycles", hi + lo, 80);
    endtask

    task automatic test_tick_hold();
        int v;
        logic g;
        tick_en = 0;
        repeat (10) @(negedge clk);
        while (fifo_level != 0) pop(v);
        pulse_stat();
        g = gate_o;
        repeat (400) @(negedge clk);
        check(gate_o == g, "R2", "gate held with tick off", gate_o, g);
        check(fifo_level == 0, "R2", "no capture with tick off", fifo_level, 0);
        check(irq == 0, "R2", "no irq with tick off", irq, 0);
        tick_en = 1;
    endtask

    task automatic test_interval_mode();
        bit ok;
        int v, c1, c2;
        do_reset(1'b1, 1'b1);
        sig_half = 1;
        // capture spacing
        wait_irq(ok, c1);
        pulse_stat();
        @(negedge clk);
        check(irq == 0, "R9", "irq cleared by status read", irq, 0);
        wait_irq(ok, c2);
        check(ok && c2 + 2 == 80, "R4", "cycles between captures", c2 + 2, 80);
        // fill the queue
        wait_level(DEPTH, ok);
        check(ok, "R5", "queue reaches depth", fifo_level, DEPTH);
        check(status[3] == 0, "R11", "no overrun before full capture", status[3], 0);
        pulse_stat();
        @(negedge clk);
        check(irq == 0, "R9", "irq cleared when full", irq, 0);
        wait_irq(ok, c1);
        check(ok && irq == 1, "R8", "irq on dropped capture", irq, 1);
        check(fifo_level == DEPTH, "R11", "level stays full", fifo_level, DEPTH);
        check(status[3] == 1, "R11", "overrun set", status[3], 1);
        check(status[4] == 0, "R12", "no wrap in interval mode", status[4], 0);
        pop(v);
        for (int k = 1; k < DEPTH; k++) begin
            pop(v);
            check(v == 40, "R6", "interval result", v, 40);
        end
        sig_half = 0;
    endtask

    task automatic test_run_mode();
        bit ok;
        int v0, v1, v2, n;
        do_reset(1'b1, 1'b0);
        sig_half = 2;
        wait_level(3, ok);
        pop(v0); pop(v1); pop(v2);
        check(((v1 - v0) & 8'hFF) == 20, "R7", "run mode delta 1", (v1 - v0) & 8'hFF, 20);
        check(((v2 - v1) & 8'hFF) == 20, "R7", "run mode delta 2", (v2 - v1) & 8'hFF, 20);
        check(v2 != 0, "R1", "count keeps running", v2, 1);
        n = 0;
        while (!status[4] && n < 3000) begin @(negedge clk); n++; end
        check(status[4] == 1, "R12", "wrap bit set", status[4], 1);
        pulse_stat();
        @(negedge clk);
        check(status[4] == 0, "R9", "wrap bit cleared by read", status[4], 0);
        sig_half = 0;
    endtask

    initial begin
        repeat (100000) @(negedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        test_reset_state();
        test_empty_read();
        test_gate_shape();
        test_tick_hold();
        test_interval_mode();
        test_run_mode();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule